// File: doc/BRIEF.md
# Bitplane Lookup Five-Tap Convolver

This block forms the weighted sum of five signed 8-bit samples without any multiplier. The five coefficients sit, already combined, in an external 32-entry table of 10-bit partial sums. Entry `a` holds the sum of the coefficients whose tap bit is set in `a`. The block handles one bit position (a bitplane) of all five samples per clock. It gathers that bit from each sample into a 5-bit table address, takes the returned partial sum, shifts it by the bit position and accumulates it. Eight bitplanes, least significant first, give the full result.

The samples are two's complement, so the most significant bitplane carries a negative weight, and its partial sum is subtracted. A register sits directly behind the table read so that the shift-add stage sees a full cycle. A new set of samples is taken while the last bitplane of the previous set is being looked up. Sets can therefore follow each other every eight cycles with no gap. The table contents are written elsewhere; this block only reads them.

Top module: `bpconv5`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `in_ready` is 1 and `tbl_addr` is 0 until a set is accepted.
- R2: A set is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next seven cycles and is 1 again in the cycle that looks up bitplane 7. This lets a new set be accepted every 8 cycles.
- R3: In the p-th cycle after the accepting edge (p = 0..7), `tbl_addr` bit i equals bit p of sample i, where sample i is `in_samples[8*i+7 : 8*i]`. When no set is in progress, `tbl_addr` is 0.
- R4: A bitplane whose address is 0 contributes zero to the result, whatever `tbl_data` returns at address 0.
- R5: `out_result` equals the sum over i of c_i × s_i, where s_i is sample i read as signed 8-bit and c_i is the coefficient implied by the table. The table is read as 10-bit two's complement and sign-extended. The result is a 21-bit two's complement value.
- R6: `out_valid` is a one-cycle pulse that rises exactly 9 cycles after the edge that accepted the set. `out_result` holds its value until the next pulse.
- R7: `in_valid` and `in_samples` are ignored while `in_ready` is 0. They neither start a set nor alter the result in progress.
- R8: Sets accepted on consecutive 8-cycle boundaries each give their own correct result, one pulse per set, in order, 8 cycles apart.
- R9: Bitplane 7 is weighted -2^7 and bitplanes 0..6 are weighted +2^p, so the most negative sample (-128) and the most positive sample (+127) both give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample set is offered |
| in_samples | input | 40 | Five samples, sample i in bits 8*i+7..8*i, two's complement |
| in_ready | output | 1 | A set offered now is taken at the next edge |
| tbl_addr | output | 5 | Partial-sum table address, bit i from sample i |
| tbl_data | input | 10 | Partial sum returned for `tbl_addr` in the same cycle, two's complement |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 21 | Convolution result, two's complement |

## Verification
Each result is due on the ninth rising edge after the edge that accepted its set. The bench tags every expected item with that cycle number, and the monitor rejects a result that arrives earlier, later or with no item waiting. Table addresses are due one per cycle starting right after the accepting edge. They are sampled on the falling edge of each of those eight cycles, together with `in_ready`. All observation happens on falling edges, half a period after the registers change, and new inputs are applied there as well.

// File: rtl/bpconv5_pkg.sv
package bpconv5_pkg;

    // Default geometry of the convolver
    localparam int unsigned DEF_TAPS     = 5;
    localparam int unsigned DEF_SAMPLE_W = 8;
    localparam int unsigned DEF_PSUM_W   = 10;

    // Role a bitplane plays in the shift-accumulate
    typedef enum logic [1:0] {
        ROLE_FIRST = 2'd0,   // restart the running sum
        ROLE_MID   = 2'd1,   // add shifted partial sum
        ROLE_SIGN  = 2'd2    // subtract shifted partial sum, result ready
    } plane_role_e;

    // Accumulator width: partial sum + sample bits + headroom for the taps
    function automatic int unsigned acc_width(input int unsigned psum_w,
                                              input int unsigned sample_w,
                                              input int unsigned taps);
        return psum_w + sample_w + $clog2(taps);
    endfunction

    function automatic plane_role_e role_of(input int unsigned plane,
                                            input int unsigned sample_w);
        if (plane == 0)
            return ROLE_FIRST;
        else if (plane == sample_w - 1)
            return ROLE_SIGN;
        else
            return ROLE_MID;
    endfunction

endpackage

// File: rtl/bpconv5_seq.sv
module bpconv5_seq
    import bpconv5_pkg::*;
#(
    parameter int unsigned TAPS     = DEF_TAPS,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned PLANE_W  = $clog2(DEF_SAMPLE_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAPS*SAMPLE_W-1:0] in_samples,
    output logic                     in_ready,
    output logic [TAPS-1:0]          tbl_addr,
    output logic                     pl_vld,
    output logic [PLANE_W-1:0]       pl_plane
);

    localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(SAMPLE_W - 1);

    typedef struct packed {
        logic                               busy;
        logic [PLANE_W-1:0]                 plane;
        logic [TAPS-1:0][SAMPLE_W-1:0]      samp;
    } seq_t;

    seq_t seq_d, seq_q;
    logic on_last;
    logic accept;

    assign on_last  = seq_q.busy && (seq_q.plane == LAST_PLANE);
    assign in_ready = !seq_q.busy || on_last;
    assign accept   = in_valid && in_ready;

    always_comb begin
        seq_d = seq_q;
        if (accept) begin
            seq_d.busy  = 1'b1;
            seq_d.plane = '0;
            seq_d.samp  = in_samples;
        end else if (on_last) begin
            seq_d.busy  = 1'b0;
            seq_d.plane = '0;
        end else if (seq_q.busy) begin
            seq_d.plane = seq_q.plane + PLANE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    // One address bit per tap: the current bit position of that tap's sample
    for (genvar g = 0; g < TAPS; g++) begin : g_addr
        assign tbl_addr[g] = seq_q.busy & seq_q.samp[g][seq_q.plane];
    end

    assign pl_vld   = seq_q.busy;
    assign pl_plane = seq_q.plane;

endmodule

// File: rtl/bpconv5_lookup.sv
module bpconv5_lookup
    import bpconv5_pkg::*;
#(
    parameter int unsigned TAPS    = DEF_TAPS,
    parameter int unsigned PSUM_W  = DEF_PSUM_W,
    parameter int unsigned PLANE_W = $clog2(DEF_SAMPLE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pl_vld,
    input  logic [PLANE_W-1:0] pl_plane,
    input  logic [TAPS-1:0]    tbl_addr,
    input  logic [PSUM_W-1:0]  tbl_data,
    output logic               lk_vld,
    output logic [PLANE_W-1:0] lk_plane,
    output logic [PSUM_W-1:0]  lk_psum
);

    typedef struct packed {
        logic               vld;
        logic [PLANE_W-1:0] plane;
        logic [PSUM_W-1:0]  psum;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d       = lk_q;
        lk_d.vld   = pl_vld;
        lk_d.plane = pl_plane;
        // Empty bitplane: no coefficient selected, so the sum is zero by definition
        lk_d.psum  = (tbl_addr == '0) ? '0 : tbl_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lk_q <= '0;
        else
            lk_q <= lk_d;
    end

    assign lk_vld   = lk_q.vld;
    assign lk_plane = lk_q.plane;
    assign lk_psum  = lk_q.psum;

endmodule

// File: rtl/bpconv5_accum.sv
module bpconv5_accum
    import bpconv5_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned PSUM_W   = DEF_PSUM_W,
    parameter int unsigned PLANE_W  = $clog2(DEF_SAMPLE_W),
    parameter int unsigned ACC_W    = acc_width(DEF_PSUM_W, DEF_SAMPLE_W, DEF_TAPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_vld,
    input  logic [PLANE_W-1:0] lk_plane,
    input  logic [PSUM_W-1:0]  lk_psum,
    output logic               out_valid,
    output logic [ACC_W-1:0]   out_result
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
        logic             res_vld;
    } acc_t;

    acc_t acc_d, acc_q;

    plane_role_e      role;
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;

    always_comb begin
        role = role_of(32'(lk_plane), SAMPLE_W);
        ext  = {{(ACC_W-PSUM_W){lk_psum[PSUM_W-1]}}, lk_psum};
        term = ext << lk_plane;
        base = (role == ROLE_FIRST) ? '0 : acc_q.acc;
        sum  = (role == ROLE_SIGN) ? (base - term) : (base + term);

        acc_d         = acc_q;
        acc_d.res_vld = 1'b0;
        if (lk_vld) begin
            acc_d.acc = sum;
            if (role == ROLE_SIGN) begin
                acc_d.res     = sum;
                acc_d.res_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign out_valid  = acc_q.res_vld;
    assign out_result = acc_q.res;

endmodule

// File: rtl/bpconv5.sv
module bpconv5
    import bpconv5_pkg::*;
#(
    parameter int unsigned TAPS     = DEF_TAPS,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned PSUM_W   = DEF_PSUM_W,
    parameter int unsigned ACC_W    = acc_width(DEF_PSUM_W, DEF_SAMPLE_W, DEF_TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAPS*SAMPLE_W-1:0] in_samples,
    output logic                     in_ready,
    output logic [TAPS-1:0]          tbl_addr,
    input  logic [PSUM_W-1:0]        tbl_data,
    output logic                     out_valid,
    output logic [ACC_W-1:0]         out_result
);

    localparam int unsigned PLANE_W = $clog2(SAMPLE_W);

    logic               pl_vld;
    logic [PLANE_W-1:0] pl_plane;
    logic               lk_vld;
    logic [PLANE_W-1:0] lk_plane;
    logic [PSUM_W-1:0]  lk_psum;

    bpconv5_seq #(
        .TAPS     (TAPS),
        .SAMPLE_W (SAMPLE_W),
        .PLANE_W  (PLANE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .in_ready   (in_ready),
        .tbl_addr   (tbl_addr),
        .pl_vld     (pl_vld),
        .pl_plane   (pl_plane)
    );

    bpconv5_lookup #(
        .TAPS    (TAPS),
        .PSUM_W  (PSUM_W),
        .PLANE_W (PLANE_W)
    ) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .pl_vld   (pl_vld),
        .pl_plane (pl_plane),
        .tbl_addr (tbl_addr),
        .tbl_data (tbl_data),
        .lk_vld   (lk_vld),
        .lk_plane (lk_plane),
        .lk_psum  (lk_psum)
    );

    bpconv5_accum #(
        .SAMPLE_W (SAMPLE_W),
        .PSUM_W   (PSUM_W),
        .PLANE_W  (PLANE_W),
        .ACC_W    (ACC_W)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vld     (lk_vld),
        .lk_plane   (lk_plane),
        .lk_psum    (lk_psum),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

endmodule

// File: rtl/bpconv5_chk.sv
module bpconv5_chk #(
    parameter int unsigned TAPS     = 5,
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned PSUM_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [TAPS-1:0]   tbl_addr,
    input logic              pl_vld,
    input logic              lk_vld,
    input logic [PSUM_W-1:0] lk_psum,
    input logic              out_valid
);

    localparam int unsigned HIST = SAMPLE_W + 2;

    // History of accepting edges, used instead of a deep $past
    logic [HIST-1:0] acc_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_hist <= '0;
        else
            acc_hist <= {acc_hist[HIST-2:0], in_valid && in_ready};
    end

    // R2: after an accepting edge the sequencer is busy
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3: no set in progress means the table address rests at zero
    p_idle_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_vld |-> (tbl_addr == '0));

    // R4: an empty bitplane registers a zero partial sum
    p_zero_plane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && ($past(tbl_addr) == '0)) |-> (lk_psum == '0));

    // R6: the strobe lasts one cycle
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: the strobe follows its accepting edge by a fixed latency
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == acc_hist[HIST-1]);

endmodule

bind bpconv5 bpconv5_chk #(
    .TAPS     (TAPS),
    .SAMPLE_W (SAMPLE_W),
    .PSUM_W   (PSUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tbl_addr  (tbl_addr),
    .pl_vld    (pl_vld),
    .lk_vld    (lk_vld),
    .lk_psum   (lk_psum),
    .out_valid (out_valid)
);

// File: tb/bpconv5_bench.sv
`timescale 1ns/1ps
module bpconv5_bench;

    localparam int TAPS = 5;
    localparam int SW   = 8;
    localparam int PW   = 10;
    localparam int AW   = 21;
    localparam int LAT  = 9;
    localparam logic [PW-1:0] POISON = 10'h155;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [TAPS*SW-1:0] in_samples = '0;
    logic               in_ready;
    logic [TAPS-1:0]    tbl_addr;
    logic [PW-1:0]      tbl_data;
    logic               out_valid;
    logic [AW-1:0]      out_result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int coef [TAPS];

    int    exp_q [$];
    int    due_q [$];
    string tag_q [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bpconv5 u_bpconv5 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .in_ready   (in_ready),
        .tbl_addr   (tbl_addr),
        .tbl_data   (tbl_data),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // Table model: sum of selected coefficients; address 0 returns a nonzero poison value
    always_comb begin
        int s;
        s = 0;
        for (int i = 0; i < TAPS; i++)
            if (tbl_addr[i]) s += coef[i];
        tbl_data = (tbl_addr == '0) ? POISON : s[PW-1:0];
    end

    function automatic int ref_mac(input logic [TAPS*SW-1:0] s);
        int acc = 0;
        for (int i = 0; i < TAPS; i++)
            acc += coef[i] * int'($signed(s[SW*i +: SW]));
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, expv);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected result strobe", int'($signed(out_result)), 0);
            end else begin
                int e, d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check(int'($signed(out_result)) == e, t, "result", int'($signed(out_result)), e);
                check(cyc == d, "R6", "result cycle", cyc, d);
            end
        end
    end

    // Driver: caller is at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [TAPS*SW-1:0] s, input string tag, input bit walk);
        in_valid   = 1'b1;
        in_samples = s;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        exp_q.push_back(ref_mac(s));
        due_q.push_back(cyc + LAT);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
        if (walk) begin
            for (int p = 0; p < SW; p++) begin
                logic [TAPS-1:0] ea;
                for (int i = 0; i < TAPS; i++) ea[i] = s[SW*i + p];
                check(tbl_addr == ea, "R3", "table address", int'(tbl_addr), int'(ea));
                check(in_ready == (p == SW-1), "R2", "ready during bitplanes",
                      int'(in_ready), int'(p == SW-1));
                if (p < SW-1) @(negedge clk);
            end
        end
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "results outstanding", exp_q.size(), 0);
    endtask

    task automatic rand_coefs();
        for (int i = 0; i < TAPS; i++) coef[i] = int'($urandom_range(200)) - 100;
    endtask

    function automatic logic [TAPS*SW-1:0] rand_set();
        logic [TAPS*SW-1:0] s;
        for (int i = 0; i < TAPS; i++) s[SW*i +: SW] = SW'($urandom_range(255));
        return s;
    endfunction

    initial begin
        coef = '{3, -7, 11, 100, -100};
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        check(tbl_addr == '0, "R1", "tbl_addr in reset", int'(tbl_addr), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready && tbl_addr == '0, "R1", "idle after reset",
              int'({out_valid, in_ready}), 1);

        // R3/R2: bit walk with a distinctive set, result R5
        send({8'h81, 8'h7E, 8'h3C, 8'hC5, 8'h5A}, "R5", 1'b1);
        drain();

        // R4: all-zero samples: every address is 0, table returns poison
        send('0, "R4", 1'b1);
        drain();

        // R9: extreme samples
        send({5{8'h80}}, "R9", 1'b0);
        drain();
        send({5{8'h7F}}, "R9", 1'b0);
        drain();
        send({8'h80, 8'h7F, 8'h80, 8'h7F, 8'hFF}, "R9", 1'b0);
        drain();

        // R7: stimulus while busy is ignored
        send({8'h12, 8'hF0, 8'h05, 8'h99, 8'h40}, "R7", 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_samples = rand_set();
            check(in_ready == 1'b0, "R7", "ready low while busy", int'(in_ready), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        drain();

        // R8: back-to-back bursts with several coefficient sets
        for (int b = 0; b < 6; b++) begin
            rand_coefs();
            for (int n = 0; n < 12; n++) send(rand_set(), "R8", 1'b0);
            drain();
        end

        // R5: single-bit samples on each tap
        for (int t = 0; t < TAPS; t++) begin
            for (int p = 0; p < SW; p++) begin
                logic [TAPS*SW-1:0] s;
                s = '0;
                s[SW*t + p] = 1'b1;
                send(s, "R5", 1'b0);
            end
        end
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule